// File: doc/BRIEF.md
# Nanosecond Time Counter with Fractional Rate Trim

This block keeps a free-running 64-bit count of nanoseconds for a 600 MHz clock domain. On each tick it adds a per-tick increment to the count. The increment is an unsigned fixed-point value with 16 integer and 32 fractional bits. The fractional part is kept in a hidden 32-bit accumulator, so a non-integer period such as 5/3 ns produces the correct long-run rate. Any carry out of the fraction goes into the nanosecond count.

Software uses a small word-addressed register port. It stages a new increment or a new start time in holding registers and then commits it with a command write. It reads the running count through two 32-bit windows. The windows are live and not latched together. A consistent 64-bit read therefore takes the sequence high, low, high, and is retried when the two high values differ.

After an increment commit, the staged increment is frozen for a fixed number of clocks. Writes to it during that window are dropped, so the committed value cannot be torn by a later write.

Top module: `nstime_core`

## Requirements
- R1: After reset, both time windows read 0 and the control word reads 0. The active increment equals the nominal value floor((10^9 << 32) / 600e6) = 0x1_AAAA_AAAA, so 6 ticks from reset give a low word of 9.
- R2: On each tick the 32-bit fraction accumulator and the 64-bit count, taken together as one value, increase by the active increment. A fraction carry adds one nanosecond. For example, an increment of 0.5 gives 5 ns after 10 ticks and 7 ns after 4 more ticks.
- R3: While control bit 0 (enable) is clear, the count and the fraction do not change.
- R4: Control bits [7:4] set the tick interval N. With enable set, a tick happens once every N clocks, and N = 0 acts as 1. The interval phase restarts whenever enable is clear.
- R5: Writing the command word (address 5) with bit 0 set copies the staged increment into the active increment. The staged increment is integer part at address 2 bits [15:0] and fraction at address 1.
- R6: Writing the command word with bit 1 set loads the count from {address 3, address 4} (high, low) and clears the fraction. This load replaces any tick in the same clock.
- R7: For the 4 clocks that follow an increment commit, writes to addresses 1 and 2 are ignored. A write in the fifth clock after the commit takes effect.
- R8: Reads return, one clock after the address is presented, the value as it was before that clock edge. Address 6 is count[63:32] and address 7 is count[31:0]. Both are live, so the high word can change between two reads. The command word (address 5) and unmapped addresses (9 to 15) read 0.
- R9: Address 8 always reads the constant 0x5A5A_0600.
- R10: The control word keeps only bits 0 (enable), [7:4] (tick interval), 8 (output enable) and [15:12] (output interval). The output enable and output interval fields have no effect on the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 600 MHz counter clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the register at `addr` |
| addr | input | 4 | Register word address, used for both read and write |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data for the previous cycle's `addr` |

## Verification
The bench builds the block with its default parameters: 16 integer and 32 fractional increment bits, a 4-bit tick interval and a 4-clock freeze window. With these values the nominal 5/3 ns increment shows truncation (4.99… ns after 3 ticks, 9 ns after 6). A start time a few counts below the 32-bit boundary brings the high-word carry and a torn high/low read within a few clocks. A half-nanosecond increment makes the fraction carry land on alternate ticks, and an interval of 3 spaces ticks across the prescaler wrap.

// File: rtl/nstime_pkg.sv
package nstime_pkg;

  localparam int DATA_W = 32;
  localparam int ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL     = 4'd0,
    A_ADD_FRAC = 4'd1,
    A_ADD_INT  = 4'd2,
    A_INIT_HI  = 4'd3,
    A_INIT_LO  = 4'd4,
    A_CMD      = 4'd5,
    A_TIME_HI  = 4'd6,
    A_TIME_LO  = 4'd7,
    A_SPARE    = 4'd8
  } reg_addr_e;

  // control word layout, msb first
  typedef struct packed {
    logic [15:0] rsv_hi;
    logic [3:0]  out_ival;
    logic [2:0]  rsv_mid;
    logic        out_en;
    logic [3:0]  tick_ival;
    logic [2:0]  rsv_lo;
    logic        en;
  } ctrl_t;

  localparam int CMD_ADDEND_BIT = 0;
  localparam int CMD_INIT_BIT   = 1;

  // nominal period of a clk_hz clock in ns, with frac_bits fractional bits
  function automatic logic [63:0] nominal_period(input longint unsigned clk_hz,
                                                 input int frac_bits);
    return (64'd1_000_000_000 << frac_bits) / clk_hz;
  endfunction

endpackage

// File: rtl/nstime_regs.sv
module nstime_regs
  import nstime_pkg::*;
#(
  parameter int INT_W     = 16,
  parameter int FRAC_W    = 32,
  parameter int HOLD_CLKS = 4,
  parameter logic [INT_W+FRAC_W-1:0] ADDEND_RST = '0
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [DATA_W-1:0]       wr_data,
  output ctrl_t                   ctrl_q,
  output logic [FRAC_W-1:0]       stage_frac,
  output logic [INT_W-1:0]        stage_int,
  output logic [DATA_W-1:0]       init_hi,
  output logic [DATA_W-1:0]       init_lo,
  output logic [INT_W+FRAC_W-1:0] active_addend,
  output logic                    load_init
);

  localparam int LOCK_W = $clog2(HOLD_CLKS + 1);

  logic              wr_cmd, set_addend, locked;
  logic [LOCK_W-1:0] lock_cnt;
  ctrl_t             ctrl_nxt;

  assign wr_cmd     = wr_en && (addr == A_CMD);
  assign set_addend = wr_cmd && wr_data[CMD_ADDEND_BIT];
  assign load_init  = wr_cmd && wr_data[CMD_INIT_BIT];
  assign locked     = (lock_cnt != '0);

  always_comb begin
    ctrl_nxt           = '0;
    ctrl_nxt.en        = wr_data[0];
    ctrl_nxt.tick_ival = wr_data[7:4];
    ctrl_nxt.out_en    = wr_data[8];
    ctrl_nxt.out_ival  = wr_data[15:12];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q        <= '0;
      stage_frac    <= '0;
      stage_int     <= '0;
      init_hi       <= '0;
      init_lo       <= '0;
      active_addend <= ADDEND_RST;
      lock_cnt      <= '0;
    end else begin
      if (set_addend) begin
        active_addend <= {stage_int, stage_frac};
        lock_cnt      <= LOCK_W'(HOLD_CLKS);
      end else if (locked) begin
        lock_cnt      <= lock_cnt - LOCK_W'(1);
      end
      if (wr_en) begin
        case (addr)
          A_CTRL:     ctrl_q <= ctrl_nxt;
          A_ADD_FRAC: if (!locked) stage_frac <= wr_data[FRAC_W-1:0];
          A_ADD_INT:  if (!locked) stage_int  <= wr_data[INT_W-1:0];
          A_INIT_HI:  init_hi <= wr_data;
          A_INIT_LO:  init_lo <= wr_data;
          default: ;
        endcase
      end
    end
  end

  // R7
  stage_hold_chk: assert property (@(posedge clk) disable iff (rst)
    locked |=> $stable(stage_frac) && $stable(stage_int));

  // R7
  lock_start_chk: assert property (@(posedge clk) disable iff (rst)
    set_addend |=> locked);

endmodule

// File: rtl/nstime_prescale.sv
module nstime_prescale #(
  parameter int IVAL_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [IVAL_W-1:0] ival,
  output logic              tick
);

  logic [IVAL_W-1:0] pcnt;
  logic [IVAL_W-1:0] ival_eff;

  assign ival_eff = (ival == '0) ? IVAL_W'(1) : ival;
  assign tick     = en && (pcnt >= ival_eff - IVAL_W'(1));

  always_ff @(posedge clk) begin
    if (rst || !en || tick) pcnt <= '0;
    else                    pcnt <= pcnt + IVAL_W'(1);
  end

  // R4
  tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && ival > IVAL_W'(1)) |=> (!tick || ival != $past(ival)));

  // R3
  idle_tick_chk: assert property (@(posedge clk) disable iff (rst)
    !en |-> !tick);

endmodule

// File: rtl/nstime_accum.sv
module nstime_accum #(
  parameter int NS_W   = 64,
  parameter int FRAC_W = 32,
  parameter int ADD_W  = 48
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             load,
  input  logic [NS_W-1:0]  load_val,
  input  logic [ADD_W-1:0] addend,
  output logic [NS_W-1:0]  ns
);

  localparam int ACC_W = NS_W + FRAC_W;

  logic [ACC_W-1:0] acc_q;
  logic [NS_W-1:0]  add_int_ext;

  assign ns          = acc_q[ACC_W-1:FRAC_W];
  assign add_int_ext = NS_W'(addend[ADD_W-1:FRAC_W]);

  always_ff @(posedge clk) begin
    if (rst)       acc_q <= '0;
    else if (load) acc_q <= {load_val, {FRAC_W{1'b0}}};
    else if (tick) acc_q <= acc_q + ACC_W'(addend);
  end

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick && !load) |=> $stable(acc_q));

  // R6
  load_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> (ns == $past(load_val)) && (acc_q[FRAC_W-1:0] == '0));

  // R2
  step_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !load) |=> ((ns - $past(ns)) == $past(add_int_ext)) ||
                        ((ns - $past(ns)) == $past(add_int_ext) + NS_W'(1)));

endmodule

// File: rtl/nstime_core.sv
module nstime_core
  import nstime_pkg::*;
#(
  parameter longint unsigned CLK_HZ = 600_000_000,
  parameter int INT_W     = 16,
  parameter int FRAC_W    = 32,
  parameter int IVAL_W    = 4,
  parameter int HOLD_CLKS = 4,
  parameter logic [31:0] SPARE_VALUE = 32'h5A5A_0600
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);

  localparam int ADD_W = INT_W + FRAC_W;
  localparam int NS_W  = 2 * DATA_W;
  localparam logic [ADD_W-1:0] NOMINAL = ADD_W'(nominal_period(CLK_HZ, FRAC_W));

  ctrl_t             ctrl_q;
  logic [FRAC_W-1:0] stage_frac;
  logic [INT_W-1:0]  stage_int;
  logic [DATA_W-1:0] init_hi, init_lo, rd_mux;
  logic [ADD_W-1:0]  active_addend;
  logic              load_init, tick;
  logic [NS_W-1:0]   ns;

  nstime_regs #(
    .INT_W(INT_W), .FRAC_W(FRAC_W), .HOLD_CLKS(HOLD_CLKS), .ADDEND_RST(NOMINAL)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .ctrl_q(ctrl_q), .stage_frac(stage_frac), .stage_int(stage_int),
    .init_hi(init_hi), .init_lo(init_lo), .active_addend(active_addend),
    .load_init(load_init)
  );

  nstime_prescale #(.IVAL_W(IVAL_W)) u_pre (
    .clk(clk), .rst(rst), .en(ctrl_q.en), .ival(ctrl_q.tick_ival[IVAL_W-1:0]),
    .tick(tick)
  );

  nstime_accum #(.NS_W(NS_W), .FRAC_W(FRAC_W), .ADD_W(ADD_W)) u_acc (
    .clk(clk), .rst(rst), .tick(tick), .load(load_init),
    .load_val({init_hi, init_lo}), .addend(active_addend), .ns(ns)
  );

  always_comb begin
    case (addr)
      A_CTRL:     rd_mux = ctrl_q;
      A_ADD_FRAC: rd_mux = DATA_W'(stage_frac);
      A_ADD_INT:  rd_mux = DATA_W'(stage_int);
      A_INIT_HI:  rd_mux = init_hi;
      A_INIT_LO:  rd_mux = init_lo;
      A_TIME_HI:  rd_mux = ns[NS_W-1:DATA_W];
      A_TIME_LO:  rd_mux = ns[DATA_W-1:0];
      A_SPARE:    rd_mux = SPARE_VALUE;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) rd_data <= rd_mux;

  // R9
  spare_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(addr) == A_SPARE) |-> (rd_data == SPARE_VALUE));

  // R8
  cmd_read_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(addr) == A_CMD) |-> (rd_data == '0));

endmodule

// File: tb/nstime_core_bench.sv
module nstime_core_bench;

  localparam real CLK_NS = 4.0;
  localparam logic [31:0] SPARE = 32'h5A5A_0600;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  nstime_core u_nstime_core (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data)
  );

  always #(CLK_NS/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // behavioural reference model
  logic [95:0] m_acc;
  logic [47:0] m_add;
  logic [31:0] m_sfrac, m_ihi, m_ilo, m_ctrl, exp_rd;
  logic [15:0] m_sint;
  int          m_pcnt, m_lock;
  bit          m_valid = 0;
  longint unsigned nom;

  initial nom = (64'd1000000000 << 32) / 64'd600000000;

  always @(posedge clk) begin
    if (rst) begin
      m_acc = '0; m_add = nom[47:0]; m_sfrac = '0; m_sint = '0;
      m_ihi = '0; m_ilo = '0; m_ctrl = '0; m_pcnt = 0; m_lock = 0;
      m_valid = 0;
    end else begin
      int ival;
      bit en, tk, was_locked;
      case (addr)
        4'd0: exp_rd = m_ctrl;
        4'd1: exp_rd = m_sfrac;
        4'd2: exp_rd = {16'h0, m_sint};
        4'd3: exp_rd = m_ihi;
        4'd4: exp_rd = m_ilo;
        4'd6: exp_rd = m_acc[95:64];
        4'd7: exp_rd = m_acc[63:32];
        4'd8: exp_rd = SPARE;
        default: exp_rd = '0;
      endcase
      m_valid = 1;
      en   = m_ctrl[0];
      ival = (m_ctrl[7:4] == 0) ? 1 : int'(m_ctrl[7:4]);
      tk   = en && (m_pcnt >= ival - 1);
      m_pcnt = (!en || tk) ? 0 : m_pcnt + 1;
      was_locked = (m_lock > 0);
      if (wr_en && addr == 4'd5 && wr_data[1]) m_acc = {m_ihi, m_ilo, 32'h0};
      else if (tk) m_acc = m_acc + {48'h0, m_add};
      if (wr_en && addr == 4'd5 && wr_data[0]) begin
        m_add = {m_sint, m_sfrac}; m_lock = 4;
      end else if (m_lock > 0) m_lock--;
      if (wr_en) begin
        case (addr)
          4'd0: m_ctrl = wr_data & 32'h0000_F1F1;
          4'd1: if (!was_locked) m_sfrac = wr_data;
          4'd2: if (!was_locked) m_sint = wr_data[15:0];
          4'd3: m_ihi = wr_data;
          4'd4: m_ilo = wr_data;
          default: ;
        endcase
      end
    end
  end

  // R8: every clock the read port matches the model
  always @(negedge clk) if (m_valid && !done) chk("R8 model", rd_data, exp_rd);

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_NS * 150000);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, h1, h2;
    longint unsigned e;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    idle(2);
    // R1 reset state
    rd(4'd6, v); chk("R1 time hi", v, 0);
    rd(4'd7, v); chk("R1 time lo", v, 0);
    rd(4'd0, v); chk("R1 ctrl", v, 0);
    // R1 nominal rate: 6 ticks
    wr(4'd0, 32'h11); idle(5); wr(4'd0, 32'h10);
    e = (6 * nom) >> 32;
    rd(4'd7, v); chk("R1 nominal 6 ticks", v, e[31:0]);
    // R2 half-ns increment with fraction carry
    wr(4'd2, 0); wr(4'd1, 32'h8000_0000); wr(4'd5, 32'h3);
    idle(5);
    wr(4'd0, 32'h11); idle(9); wr(4'd0, 32'h10);
    rd(4'd7, v); chk("R2 10 half ticks", v, 5);
    // R3 disabled holds
    idle(20);
    rd(4'd7, v); chk("R3 hold while disabled", v, 5);
    wr(4'd0, 32'h11); idle(2); wr(4'd0, 32'h10);
    rd(4'd7, v); chk("R2 odd half ticks", v, 6);
    wr(4'd0, 32'h11); wr(4'd0, 32'h10);
    rd(4'd7, v); chk("R2 fraction carry", v, 7);
    // R4 tick interval 3, then 0 acting as 1
    wr(4'd2, 1); wr(4'd1, 0); wr(4'd5, 32'h3);
    idle(5);
    wr(4'd0, 32'h31); idle(11); wr(4'd0, 32'h30);
    rd(4'd7, v); chk("R4 interval 3", v, 4);
    wr(4'd0, 32'h01); idle(4); wr(4'd0, 32'h00);
    rd(4'd7, v); chk("R4 interval 0 as 1", v, 9);
    // R6 init while running, with high carry
    wr(4'd3, 0); wr(4'd4, 32'hFFFF_FFF0);
    wr(4'd0, 32'h11); wr(4'd5, 32'h2); idle(19); wr(4'd0, 32'h10);
    rd(4'd6, v); chk("R6 init hi", v, 1);
    rd(4'd7, v); chk("R6 init lo", v, 4);
    // R8 live halves torn across a carry
    wr(4'd3, 5); wr(4'd4, 32'hFFFF_FFFE);
    wr(4'd0, 32'h11); wr(4'd5, 32'h2);
    rd(4'd6, h1); rd(4'd7, v); rd(4'd6, h2);
    wr(4'd0, 32'h10);
    chk("R8 first hi", h1, 5);
    chk("R8 lo", v, 32'hFFFF_FFFF);
    chk("R8 second hi", h2, 6);
    // R7 staged increment frozen after commit
    idle(6);
    wr(4'd2, 3); wr(4'd1, 0); wr(4'd5, 32'h1);
    wr(4'd2, 7);
    rd(4'd2, v); chk("R7 write in window ignored", v, 3);
    idle(5);
    wr(4'd2, 7);
    rd(4'd2, v); chk("R7 write after window", v, 7);
    // R5 and R10: committed increment 3, output fields set
    wr(4'd3, 0); wr(4'd4, 0); wr(4'd5, 32'h2);
    wr(4'd0, 32'h3111); idle(3); wr(4'd0, 32'h0);
    rd(4'd7, v); chk("R5 R10 committed rate", v, 12);
    // R10 readback mask, R9 spare, R8 command reads 0
    wr(4'd0, 32'hFFFF_FEFE);
    rd(4'd0, v); chk("R10 ctrl mask", v, 32'h0000_F0F0);
    rd(4'd8, v); chk("R9 spare", v, SPARE);
    rd(4'd5, v); chk("R8 cmd reads 0", v, 0);
    rd(4'd12, v); chk("R8 unmapped", v, 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule